// File: doc/BRIEF.md
# Two-Byte-Address Serial Memory Slave

This block is the bus-facing slave of a byte-wide memory with 32K locations, reached over the two-wire I2C protocol. A system clock oversamples the clock and data lines. The block finds START and STOP conditions and takes in the slave-address byte. It compares that byte with a fixed device type and with three strap pins, then collects a two-byte array address. It answers the master through an open-drain pull-down enable. Each accepted data byte becomes one request on a simple request/acknowledge port toward the memory side. Read bytes are fetched through the same port and shifted out MSB first.

The memory side reports its internal programming cycle through a busy input. While that input is high the block ignores its own address, so the master can poll with repeated START plus a write-direction address until it sees an acknowledge. A write-protect input lets every address byte through but refuses the data. When a write transaction ends with STOP, a one-cycle program pulse tells the memory side to start programming.

Top module: `twobyte_i2c_slave`

## Requirements
- R1: After reset the block does not pull the data line, issues no memory request and gives no program pulse.
- R2: The slave-address byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal dev_sel_i. Bit 0 selects the direction (1 = read). A byte that does not match is not acknowledged, and the block stays silent until the next START.
- R3: After a write-direction address, a high address byte and then a low address byte are received and acknowledged. Bit 7 of the high byte is ignored, and the bits left form a 15-bit address, {high[6:0], low[7:0]}.
- R4: Each accepted data byte gives exactly one write request at the current address. The address then advances in its low 6 bits only, so writes wrap inside a 64-byte page. A request stays up with stable address, data and direction until mem_ack_i.
- R5: prog_o pulses for one cycle at a STOP if, and only if, at least one data byte was accepted since the last START.
- R6: With wp_i high, the slave-address and both address bytes are acknowledged. The first data byte is not acknowledged, no write request is made and no program pulse follows the STOP.
- R7: With busy_i high when the slave-address byte completes, that byte is not acknowledged.
- R8: A read-direction address sends the byte at the address just loaded, MSB first. Each master ACK sends the next byte, advancing through the full 15-bit range and wrapping from 0x7FFF to 0x0000.
- R9: A read that follows no new address load starts one past the last byte accessed, whether that byte was read or written.
- R10: After a master NACK or a STOP, the block releases the data line and leaves it released.
- R11: A START in any state abandons the transfer in progress and restarts slave-address reception.
- R12: The pull-down enable is only ever switched on while the synchronized clock is low. Acknowledges are driven across the 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 (open drain) |
| dev_sel_i | input | 3 | Strapped device select bits |
| wp_i | input | 1 | Write protect for the whole array |
| busy_i | input | 1 | Memory side is programming |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write when 1 |
| mem_addr_o | output | 15 | Request address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Memory side completes the request |
| mem_rdata_i | input | 8 | Read data, valid with mem_ack_i |
| prog_o | output | 1 | One-cycle pulse: start the program cycle |

## Verification
Some properties are checked on every cycle. The pull-down only comes on while the clock is low, and the line is always free when the block is idle. A pending request holds steady until acknowledged, and no write request follows a cycle with write protect high. The program pulse lasts one cycle and only follows a detected STOP, and the page-internal write address never carries into its upper bits. Address matching, the ignored high-address bit, the page wrap, the full-range read wrap, the current-address continuation, polling under busy and START abort can only be shown by the bench. It drives whole bus transactions and compares the acknowledges and returned bytes with a reference memory model of its own.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADRH,
    ST_ADRL,
    ST_WDAT,
    ST_RDAT
  } st_e;
endpackage

// File: rtl/tbs_sync.sv
module tbs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/tbs_cond_det.sv
module tbs_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  // data edges only count while clock is high on both samples
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/tbs_addr_ctr.sv
module tbs_addr_ctr #(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_hi_i,
  input  logic          ld_lo_i,
  input  logic [AW-9:0] hi_i,
  input  logic [7:0]    lo_i,
  input  logic          inc_rd_i,
  input  logic          inc_wr_i,
  output logic [AW-1:0] addr_o
);
  localparam int HW = AW - 8;

  logic [HW-1:0] hi_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (ld_hi_i) hi_q <= hi_i;
      if (ld_lo_i)       addr_q <= {hi_q, lo_i};
      else if (inc_rd_i) addr_q <= addr_q + 1'b1;
      else if (inc_wr_i) addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
    end
  end

  assign addr_o = addr_q;

  // R4
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_wr_i |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]));
endmodule

// File: rtl/twobyte_i2c_slave.sv
module twobyte_i2c_slave
  import tbs_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 6,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        dev_sel_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              prog_o
);
  localparam int HW = ADDR_W - 8;

  logic [1:0] line_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tbs_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({sda_i, scl_i}), .q_o(line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  tbs_cond_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  st_e         st_q, nxt_q, byte_nxt;
  logic [3:0]  bit_cnt_q;
  logic        ack_ph_q, sda_oe_q, dirty_q, prog_q, mack_q;
  logic [7:0]  sh_q, txsh_q, tx_q;
  logic        ld_hi_q, ld_lo_q, inc_rd_q, inc_wr_q;
  logic        req_q, we_q;
  logic [ADDR_W-1:0] maddr_q, addr;
  logic [7:0]  wdata_q;
  logic        byte_ok, addr_hit;

  tbs_addr_ctr #(.AW(ADDR_W), .PW(PAGE_BITS)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_hi_i(ld_hi_q), .ld_lo_i(ld_lo_q),
    .hi_i(sh_q[HW-1:0]), .lo_i(sh_q),
    .inc_rd_i(inc_rd_q), .inc_wr_i(inc_wr_q),
    .addr_o(addr)
  );

  assign addr_hit = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == dev_sel_i);

  always_comb begin
    byte_ok  = 1'b0;
    byte_nxt = ST_IDLE;
    unique case (st_q)
      ST_DEV:  begin byte_ok = addr_hit && !busy_i; byte_nxt = sh_q[0] ? ST_RDAT : ST_ADRH; end
      ST_ADRH: begin byte_ok = 1'b1; byte_nxt = ST_ADRL; end
      ST_ADRL: begin byte_ok = 1'b1; byte_nxt = ST_WDAT; end
      ST_WDAT: begin byte_ok = !wp_i; byte_nxt = ST_WDAT; end
      default: begin byte_ok = 1'b0; byte_nxt = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      dirty_q   <= 1'b0;
      prog_q    <= 1'b0;
      mack_q    <= 1'b0;
      sh_q      <= '0;
      txsh_q    <= '1;
      tx_q      <= '0;
      ld_hi_q   <= 1'b0;
      ld_lo_q   <= 1'b0;
      inc_rd_q  <= 1'b0;
      inc_wr_q  <= 1'b0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      maddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      ld_hi_q  <= 1'b0;
      ld_lo_q  <= 1'b0;
      inc_rd_q <= 1'b0;
      inc_wr_q <= 1'b0;
      prog_q   <= 1'b0;

      if (req_q && mem_ack_i) begin
        req_q <= 1'b0;
        if (!we_q) tx_q <= mem_rdata_i;
      end

      if (start_det) begin
        st_q      <= ST_DEV;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_q  <= 1'b0;
        dirty_q   <= 1'b0;
      end else if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
        ack_ph_q <= 1'b0;
        prog_q   <= dirty_q;
        dirty_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if (scl_fall && bit_cnt_q == 4'd8) begin
              if (!ack_ph_q) begin
                if (byte_ok) begin
                  sda_oe_q <= 1'b1;
                  ack_ph_q <= 1'b1;
                  nxt_q    <= byte_nxt;
                  if (st_q == ST_DEV && sh_q[0]) begin
                    req_q    <= 1'b1;
                    we_q     <= 1'b0;
                    maddr_q  <= addr;
                    inc_rd_q <= 1'b1;
                  end
                  if (st_q == ST_ADRH) ld_hi_q <= 1'b1;
                  if (st_q == ST_ADRL) ld_lo_q <= 1'b1;
                  if (st_q == ST_WDAT) begin
                    req_q    <= 1'b1;
                    we_q     <= 1'b1;
                    maddr_q  <= addr;
                    wdata_q  <= sh_q;
                    inc_wr_q <= 1'b1;
                    dirty_q  <= 1'b1;
                  end
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                ack_ph_q  <= 1'b0;
                bit_cnt_q <= '0;
                st_q      <= nxt_q;
                if (nxt_q == ST_RDAT) begin
                  sda_oe_q <= !tx_q[7];
                  txsh_q   <= {tx_q[6:0], 1'b1};
                end else begin
                  sda_oe_q <= 1'b0;
                end
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              if (bit_cnt_q < 4'd8) begin
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end else if (bit_cnt_q == 4'd8) begin
                bit_cnt_q <= 4'd9;
                mack_q    <= !sda_s;
                if (!sda_s) begin
                  req_q    <= 1'b1;
                  we_q     <= 1'b0;
                  maddr_q  <= addr;
                  inc_rd_q <= 1'b1;
                end
              end
            end
            if (scl_fall) begin
              if (bit_cnt_q >= 4'd1 && bit_cnt_q <= 4'd7) begin
                sda_oe_q <= !txsh_q[7];
                txsh_q   <= {txsh_q[6:0], 1'b1};
              end else if (bit_cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
              end else if (bit_cnt_q == 4'd9) begin
                if (mack_q) begin
                  bit_cnt_q <= '0;
                  sda_oe_q  <= !tx_q[7];
                  txsh_q    <= {tx_q[6:0], 1'b1};
                end else begin
                  st_q     <= ST_IDLE;
                  sda_oe_q <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = wdata_q;
  assign prog_o      = prog_q;

  // R12
  oe_low_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R6
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && mem_we_o) |-> !$past(wp_i));
  // R5
  prog_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> $past(stop_det) && !$past(prog_o));
endmodule

// File: tb/twobyte_i2c_slave_bench.sv
module twobyte_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int BUSY_CLKS  = 600;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, wp = 1'b0, busy;
  logic mem_req, mem_we, mem_ack = 1'b0, prog;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic sda_bus;

  int n_chk = 0, n_fail = 0, prog_cnt = 0, wr_cnt = 0, busy_cnt = 0, dly = 0;
  int cur_addr = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [int];
  logic [7:0] exp_m [int];
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign busy = (busy_cnt != 0);

  twobyte_i2c_slave u_twobyte_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .dev_sel_i(3'b101), .wp_i(wp), .busy_i(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .prog_o(prog)
  );

  function automatic logic [7:0] dflt(input int a);
    return 8'((a & 255) ^ ((a >> 7) & 255) ^ 90);
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    return exp_m.exists(a) ? exp_m[a] : dflt(a);
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (prog) busy_cnt <= BUSY_CLKS;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (prog) prog_cnt = prog_cnt + 1;
    if (mem_req && !mem_ack) begin
      if (dly == 1) begin
        dly <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_m[int'(mem_addr)] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : dflt(int'(mem_addr));
        end
      end else dly <= dly + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_bus;
    scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_bus}; scl = 1'b0;
    end
    tick(2); sda_m = !give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  // addr is 16 bits as sent; the design keeps 15 of them
  task automatic do_write(input int a, input int n, input bit acc, input string tag);
    bit k;
    bus_start();
    wr_byte(DEV_W, k);            check({tag, " R2 dev ack"}, k, 1);
    wr_byte(8'(a >> 8), k);       check({tag, " R3 hi ack"}, k, 1);
    wr_byte(8'(a), k);            check({tag, " R3 lo ack"}, k, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], k);
      if (acc) check({tag, " R4 data ack"}, k, 1);
      else begin check({tag, " R6 data nack"}, k, 0); break; end
    end
    bus_stop();
    if (acc) begin
      for (int i = 0; i < n; i++)
        exp_m[(a & 32'h7FC0) | ((a + i) & 63)] = wbuf[i];
      cur_addr = (a & 32'h7FC0) | ((a + n) & 63);
    end else cur_addr = a & 32'h7FFF;
  endtask

  task automatic read_body(input int a, input int n, input string tag);
    logic [7:0] b;
    bit k;
    wr_byte(DEV_R, k); check({tag, " R2 read dev ack"}, k, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, b);
      check({tag, " R8 data"}, b, exp_rd((a + i) & 32'h7FFF));
    end
    tick(Q);
    check({tag, " R10 released after nack"}, sda_oe, 0);
    bus_stop();
    tick(4);
    check({tag, " R10 released after stop"}, sda_oe, 0);
    cur_addr = (a + n) & 32'h7FFF;
  endtask

  task automatic do_rand_read(input int a, input int n, input string tag);
    bit k;
    bus_start();
    wr_byte(DEV_W, k);      check({tag, " R2 dev ack"}, k, 1);
    wr_byte(8'(a >> 8), k); check({tag, " R3 hi ack"}, k, 1);
    wr_byte(8'(a), k);      check({tag, " R3 lo ack"}, k, 1);
    bus_start();
    read_body(a & 32'h7FFF, n, tag);
  endtask

  task automatic do_cur_read(input int n, input string tag);
    bus_start();
    read_body(cur_addr, n, tag);
  endtask

  task automatic wait_ready(input string tag);
    bit k;
    k = 1'b0;
    for (int t = 0; t < 40; t++) begin
      bus_start(); wr_byte(DEV_W, k); bus_stop();
      if (k) break;
      tick(50);
    end
    check({tag, " R7 poll finally acked"}, k, 1);
  endtask

  initial begin
    bit k;
    int p0, w0, a, n;
    void'($urandom(32'd1234));
    tick(5);
    check("R1 oe at reset", sda_oe, 0);
    check("R1 req at reset", mem_req, 0);
    check("R1 prog at reset", prog, 0);
    rst_n = 1'b1;
    tick(5);

    // R2: wrong type and wrong select are ignored
    bus_start(); wr_byte(8'hBA, k); check("R2 wrong type nack", k, 0);
    wr_byte(8'h00, k); check("R2 silent after mismatch", k, 0); bus_stop();
    bus_start(); wr_byte(8'hA8, k); check("R2 wrong select nack", k, 0); bus_stop();

    // R3/R4/R5/R7: write with top address bit set
    p0 = prog_cnt; w0 = wr_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(32'h8123, 3, 1'b1, "dw1");
    check("R5 one prog pulse", prog_cnt - p0, 1);
    check("R4 three writes", wr_cnt - w0, 3);
    bus_start(); wr_byte(DEV_W, k); check("R7 busy nack", k, 0); bus_stop();
    wait_ready("dw1");
    do_rand_read(32'h0123, 3, "rr1");

    // R4 page wrap
    w0 = wr_cnt;
    wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
    do_write(32'h027E, 4, 1'b1, "pw");
    check("R4 page wrap writes", wr_cnt - w0, 4);
    wait_ready("pw");
    do_rand_read(32'h0240, 2, "pw R4 wrapped");
    do_rand_read(32'h027E, 2, "pw R4 tail");

    // R9 current address continues after last read
    do_cur_read(2, "R9 cur after read");
    wbuf[0] = 8'h5C;
    do_write(32'h1000, 1, 1'b1, "cw");
    wait_ready("cw");
    do_cur_read(1, "R9 cur after write");

    // R8 full-range wrap
    do_rand_read(32'h7FFE, 4, "R8 wrap");

    // R6 write protect
    wp = 1'b1; p0 = prog_cnt; w0 = wr_cnt;
    wbuf[0] = 8'hEE;
    do_write(32'h0300, 1, 1'b0, "wp");
    tick(10);
    check("R6 no write req", wr_cnt - w0, 0);
    check("R6 no prog", prog_cnt - p0, 0);
    wp = 1'b0;
    do_rand_read(32'h0300, 1, "R6 unchanged");

    // R11 START mid-byte aborts
    bus_start(); wr_byte(DEV_W, k); wr_byte(8'h01, k);
    send_bits(8'hFF, 3);
    do_rand_read(32'h0124, 2, "R11 after abort");
    p0 = prog_cnt;
    bus_start(); wr_byte(DEV_W, k); wr_byte(8'h00, k); send_bits(8'h55, 5);
    bus_start(); wr_byte(8'h00, k); check("R11 restart dev phase", k, 0); bus_stop();
    check("R5 no prog without data", prog_cnt - p0, 0);

    // random transactions
    for (int it = 0; it < 8; it++) begin
      a = $urandom & 32'hFFFF;
      n = 1 + ($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, 1'b1, "rnd");
      wait_ready("rnd");
      do_rand_read(a & 32'h7FC0 | (a & 63), n, "rnd");
      if (it % 2 == 1) do_cur_read(2, "rnd R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule